// File: doc/BRIEF.md
# Virtual CPU Interrupt Source Picker with Acknowledge

This block decides which pending interrupt a virtual CPU should take next. It looks at five candidates: a non-maskable interrupt, a machine-check, an event-callback vector, the output of the legacy interrupt controller (PIC), and the highest pending vector of the local APIC. It reports the winning source and its vector combinationally. It also raises a delivery request whenever something is selected and the CPU is not blocking interrupts.

The non-maskable and machine-check requests are held inside the block as pending flags. One-cycle strobes set them. The other three candidates come in as level inputs from their own models. To take an interrupt, the caller presents an acknowledge request that names a source and a vector. In that same cycle the block checks the named source again, pulsing an acknowledge strobe toward the PIC or the APIC when needed. One cycle later it returns a confirmed source and vector. If the source has gone away in the meantime, it returns "none" instead.

Top module: `irq_pick_ack`

## Requirements
- R1: The selection follows a fixed order: non-maskable first, then machine-check, then callback vector, then PIC, then APIC. Sources are encoded in 3 bits: 0 none, 1 non-maskable, 2 machine-check, 3 callback, 4 PIC, 5 APIC. The reported vector is NMI_VEC (default 2) for non-maskable, MCE_VEC (default 18) for machine-check, and 0 for PIC and none.
- R2: The callback source can be selected only while `via_is_vector` and `evt_pending` are both high. It reports `cb_vector`.
- R3: The PIC source can be selected only while `apic_accepts_pic` and `pic_out` are both high.
- R4: The APIC source can be selected whenever `apic_valid` is high, and it reports `apic_vector`.
- R5: A strobe on `nmi_set` or `mce_set` makes that flag pending from the next cycle on. Acknowledging that source clears the flag, and a set strobe in the same cycle wins over the clear. If the flag was already clear when acknowledged, the result is "none" with vector 0. Otherwise the result is the source with its fixed vector.
- R6: A PIC acknowledge pulses `pic_ack_stb` in the same cycle. The result is the PIC source with `pic_ack_vec` if `pic_ack_valid` is high, and "none" otherwise.
- R7: An APIC acknowledge pulses `apic_ack_stb` in the same cycle, with `apic_ack_vec` equal to `ack_vec`. The result is the APIC source with `ack_vec` if `apic_ack_ok` is high, and "none" otherwise.
- R8: A callback acknowledge returns source 3 with `ack_vec` unchanged. Codes 0, 6 and 7 acknowledge as "none" with vector 0.
- R9: `ack_done` is high in exactly the cycle after the cycle in which `ack_req` was high, and the acknowledge result is valid while it is high.
- R10: `need_delivery` is high exactly when the selected source is not "none" and `blocked` is low.
- R11: After reset both flags are clear, no source is selected and `ack_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_set | input | 1 | Strobe that makes a non-maskable interrupt pending |
| mce_set | input | 1 | Strobe that makes a machine-check pending |
| via_is_vector | input | 1 | Callback delivery is configured as a direct vector |
| evt_pending | input | 1 | Event upcall pending |
| cb_vector | input | 8 | Callback vector number |
| apic_accepts_pic | input | 1 | APIC currently accepts PIC interrupts |
| pic_out | input | 1 | Output of the primary PIC |
| apic_valid | input | 1 | APIC has a pending vector |
| apic_vector | input | 8 | APIC highest pending vector |
| blocked | input | 1 | CPU is currently blocking interrupt delivery |
| ack_req | input | 1 | Acknowledge request |
| ack_src | input | 3 | Source code being acknowledged |
| ack_vec | input | 8 | Vector being acknowledged |
| pic_ack_stb | output | 1 | Acknowledge strobe to the PIC |
| pic_ack_valid | input | 1 | PIC returned a vector for this acknowledge |
| pic_ack_vec | input | 8 | Vector returned by the PIC |
| apic_ack_stb | output | 1 | Acknowledge strobe to the APIC |
| apic_ack_vec | output | 8 | Vector offered to the APIC for acknowledge |
| apic_ack_ok | input | 1 | APIC accepted the acknowledge |
| sel_src | output | 3 | Selected source code |
| sel_vec | output | 8 | Selected vector |
| need_delivery | output | 1 | A source is selected and delivery is not blocked |
| ack_done | output | 1 | Acknowledge result valid |
| ack_res_src | output | 3 | Confirmed source, 0 if the source vanished |
| ack_res_vec | output | 8 | Confirmed vector |

## Verification
The properties assume that the PIC and APIC answers (`pic_ack_valid`, `pic_ack_vec`, `apic_ack_ok`) are combinational replies sampled in the cycle of their strobe. They also assume that any 3-bit code may appear on `ack_src`, including codes no source uses. The stimulus drives those answers freely in every cycle and draws `ack_src` over the full 0 to 7 range. As a result, stale acknowledges, refused acknowledges and unknown codes all occur alongside strobes that set flags in the same cycle. Every source level is changed only after a falling clock edge, so the combinational selection is always judged against stable inputs.

// File: rtl/irq_pick_pkg.sv
package irq_pick_pkg;

    localparam int VEC_W = 8;
    localparam int SRC_W = 3;
    localparam int N_FLAG = 2;   // held flags: index 0 non-maskable, 1 machine-check

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE = 3'd0,
        SRC_NMI  = 3'd1,
        SRC_MCE  = 3'd2,
        SRC_CBV  = 3'd3,
        SRC_PIC  = 3'd4,
        SRC_APIC = 3'd5
    } src_e;

    typedef struct packed {
        src_e             src;
        logic [VEC_W-1:0] vec;
    } pick_t;

    function automatic pick_t mk_pick(src_e s, logic [VEC_W-1:0] v);
        pick_t p;
        p.src = s;
        p.vec = v;
        return p;
    endfunction

    function automatic pick_t no_pick();
        return mk_pick(SRC_NONE, '0);
    endfunction

endpackage

// File: rtl/irq_pend_flags.sv
module irq_pend_flags
    import irq_pick_pkg::*;
#(
    parameter int N = N_FLAG
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                pend_o[i] <= 1'b0;
            else if (set_i[i])
                pend_o[i] <= 1'b1;     // a new request beats a same-cycle consume
            else if (clr_i[i])
                pend_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_pick_pkg::*;
#(
    parameter logic [VEC_W-1:0] NMI_VEC = 8'd2,
    parameter logic [VEC_W-1:0] MCE_VEC = 8'd18
) (
    input  logic             nmi_p,
    input  logic             mce_p,
    input  logic             via_is_vector,
    input  logic             evt_pending,
    input  logic [VEC_W-1:0] cb_vector,
    input  logic             apic_accepts_pic,
    input  logic             pic_out,
    input  logic             apic_valid,
    input  logic [VEC_W-1:0] apic_vector,
    output pick_t            pick_o
);
    always_comb begin
        if (nmi_p)
            pick_o = mk_pick(SRC_NMI, NMI_VEC);
        else if (mce_p)
            pick_o = mk_pick(SRC_MCE, MCE_VEC);
        else if (via_is_vector && evt_pending)
            pick_o = mk_pick(SRC_CBV, cb_vector);
        else if (apic_accepts_pic && pic_out)
            pick_o = mk_pick(SRC_PIC, '0);
        else if (apic_valid)
            pick_o = mk_pick(SRC_APIC, apic_vector);
        else
            pick_o = no_pick();
    end
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
    import irq_pick_pkg::*;
#(
    parameter logic [VEC_W-1:0] NMI_VEC = 8'd2,
    parameter logic [VEC_W-1:0] MCE_VEC = 8'd18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ack_req,
    input  logic [SRC_W-1:0]  ack_src,
    input  logic [VEC_W-1:0]  ack_vec,
    input  logic [N_FLAG-1:0] pend,
    input  logic              pic_ack_valid,
    input  logic [VEC_W-1:0]  pic_ack_vec,
    input  logic              apic_ack_ok,
    output logic              pic_ack_stb,
    output logic              apic_ack_stb,
    output logic [VEC_W-1:0]  apic_ack_vec,
    output logic [N_FLAG-1:0] clr,
    output logic              ack_done,
    output pick_t             ack_res
);
    pick_t res_d;

    always_comb begin
        res_d        = no_pick();
        clr          = '0;
        pic_ack_stb  = 1'b0;
        apic_ack_stb = 1'b0;
        apic_ack_vec = ack_vec;
        if (ack_req) begin
            case (ack_src)
                SRC_NMI: begin
                    clr[0] = 1'b1;
                    if (pend[0]) res_d = mk_pick(SRC_NMI, NMI_VEC);
                end
                SRC_MCE: begin
                    clr[1] = 1'b1;
                    if (pend[1]) res_d = mk_pick(SRC_MCE, MCE_VEC);
                end
                SRC_CBV: res_d = mk_pick(SRC_CBV, ack_vec);
                SRC_PIC: begin
                    pic_ack_stb = 1'b1;
                    if (pic_ack_valid) res_d = mk_pick(SRC_PIC, pic_ack_vec);
                end
                SRC_APIC: begin
                    apic_ack_stb = 1'b1;
                    if (apic_ack_ok) res_d = mk_pick(SRC_APIC, ack_vec);
                end
                default: res_d = no_pick();
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_done <= 1'b0;
            ack_res  <= no_pick();
        end else begin
            ack_done <= ack_req;
            if (ack_req) ack_res <= res_d;
        end
    end
endmodule

// File: rtl/irq_pick_ack.sv
module irq_pick_ack
    import irq_pick_pkg::*;
#(
    parameter logic [VEC_W-1:0] NMI_VEC = 8'd2,
    parameter logic [VEC_W-1:0] MCE_VEC = 8'd18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nmi_set,
    input  logic             mce_set,
    input  logic             via_is_vector,
    input  logic             evt_pending,
    input  logic [VEC_W-1:0] cb_vector,
    input  logic             apic_accepts_pic,
    input  logic             pic_out,
    input  logic             apic_valid,
    input  logic [VEC_W-1:0] apic_vector,
    input  logic             blocked,
    input  logic             ack_req,
    input  logic [SRC_W-1:0] ack_src,
    input  logic [VEC_W-1:0] ack_vec,
    output logic             pic_ack_stb,
    input  logic             pic_ack_valid,
    input  logic [VEC_W-1:0] pic_ack_vec,
    output logic             apic_ack_stb,
    output logic [VEC_W-1:0] apic_ack_vec,
    input  logic             apic_ack_ok,
    output logic [SRC_W-1:0] sel_src,
    output logic [VEC_W-1:0] sel_vec,
    output logic             need_delivery,
    output logic             ack_done,
    output logic [SRC_W-1:0] ack_res_src,
    output logic [VEC_W-1:0] ack_res_vec
);
    logic [N_FLAG-1:0] pend;
    logic [N_FLAG-1:0] clr;
    pick_t             pick;
    pick_t             res;

    irq_pend_flags #(.N(N_FLAG)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  ({mce_set, nmi_set}),
        .clr_i  (clr),
        .pend_o (pend)
    );

    irq_prio_sel #(.NMI_VEC(NMI_VEC), .MCE_VEC(MCE_VEC)) u_sel (
        .nmi_p            (pend[0]),
        .mce_p            (pend[1]),
        .via_is_vector    (via_is_vector),
        .evt_pending      (evt_pending),
        .cb_vector        (cb_vector),
        .apic_accepts_pic (apic_accepts_pic),
        .pic_out          (pic_out),
        .apic_valid       (apic_valid),
        .apic_vector      (apic_vector),
        .pick_o           (pick)
    );

    irq_ack_unit #(.NMI_VEC(NMI_VEC), .MCE_VEC(MCE_VEC)) u_ack (
        .clk           (clk),
        .rst           (rst),
        .ack_req       (ack_req),
        .ack_src       (ack_src),
        .ack_vec       (ack_vec),
        .pend          (pend),
        .pic_ack_valid (pic_ack_valid),
        .pic_ack_vec   (pic_ack_vec),
        .apic_ack_ok   (apic_ack_ok),
        .pic_ack_stb   (pic_ack_stb),
        .apic_ack_stb  (apic_ack_stb),
        .apic_ack_vec  (apic_ack_vec),
        .clr           (clr),
        .ack_done      (ack_done),
        .ack_res       (res)
    );

    assign sel_src       = pick.src;
    assign sel_vec       = pick.vec;
    assign need_delivery = (pick.src != SRC_NONE) && !blocked;
    assign ack_res_src   = res.src;
    assign ack_res_vec   = res.vec;
endmodule

// File: rtl/irq_pick_chk.sv
module irq_pick_chk (
    input logic       clk,
    input logic       rst,
    input logic       nmi_set,
    input logic       via_is_vector,
    input logic       evt_pending,
    input logic       apic_accepts_pic,
    input logic       pic_out,
    input logic       blocked,
    input logic       ack_req,
    input logic [2:0] ack_src,
    input logic [7:0] ack_vec,
    input logic       pic_ack_stb,
    input logic       apic_ack_stb,
    input logic [2:0] sel_src,
    input logic       need_delivery,
    input logic       ack_done,
    input logic [2:0] ack_res_src,
    input logic [7:0] ack_res_vec
);
    // R1
    src_code_range_chk: assert property (@(posedge clk) disable iff (rst)
        sel_src <= 3'd5);
    // R2
    cbv_gate_chk: assert property (@(posedge clk) disable iff (rst)
        sel_src == 3'd3 |-> via_is_vector && evt_pending);
    // R3
    pic_gate_chk: assert property (@(posedge clk) disable iff (rst)
        sel_src == 3'd4 |-> apic_accepts_pic && pic_out);
    // R5
    nmi_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_set |=> sel_src == 3'd1);
    // R5
    nmi_consumed_chk: assert property (@(posedge clk) disable iff (rst)
        ack_req && ack_src == 3'd1 && !nmi_set |=> sel_src != 3'd1);
    // R6
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pic_ack_stb, apic_ack_stb}));
    // R8
    cbv_pass_chk: assert property (@(posedge clk) disable iff (rst)
        ack_req && ack_src == 3'd3 |=> ack_res_src == 3'd3 && ack_res_vec == $past(ack_vec));
    // R8
    unknown_none_chk: assert property (@(posedge clk) disable iff (rst)
        ack_req && ack_src > 3'd5 |=> ack_res_src == 3'd0);
    // R9
    done_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_req |=> !ack_done);
    // R10
    blocked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        blocked |-> !need_delivery);
endmodule

bind irq_pick_ack irq_pick_chk chk_i (.*);

// File: tb/irq_pick_ack_tb.sv
module irq_pick_ack_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nmi_set, mce_set, via_is_vector, evt_pending, apic_accepts_pic, pic_out;
    logic apic_valid, blocked, ack_req, pic_ack_valid, apic_ack_ok;
    logic [7:0] cb_vector, apic_vector, ack_vec, pic_ack_vec;
    logic [2:0] ack_src;
    logic pic_ack_stb, apic_ack_stb, need_delivery, ack_done;
    logic [7:0] apic_ack_vec, sel_vec, ack_res_vec;
    logic [2:0] sel_src, ack_res_src;

    int n_chk = 0;
    int n_err = 0;
    int m_nmi = 0;
    int m_mce = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pick_ack dut_i (.*);

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic quiet();
        nmi_set = 0; mce_set = 0; via_is_vector = 0; evt_pending = 0; cb_vector = 8'h40;
        apic_accepts_pic = 0; pic_out = 0; apic_valid = 0; apic_vector = 8'h31;
        blocked = 0; ack_req = 0; ack_src = 0; ack_vec = 0;
        pic_ack_valid = 0; pic_ack_vec = 8'h08; apic_ack_ok = 0;
    endtask

    // One clock: inputs already set after a falling edge.
    task automatic step();
        int es, ev, rs, rv, nn, nm;
        string t;
        #1;
        if (m_nmi != 0)                       begin es = 1; ev = 2;           t = "R1"; end
        else if (m_mce != 0)                  begin es = 2; ev = 18;          t = "R1"; end
        else if (via_is_vector && evt_pending) begin es = 3; ev = cb_vector;  t = "R2"; end
        else if (apic_accepts_pic && pic_out) begin es = 4; ev = 0;           t = "R3"; end
        else if (apic_valid)                  begin es = 5; ev = apic_vector; t = "R4"; end
        else                                  begin es = 0; ev = 0;           t = "R1"; end
        chk({t, " sel_src"}, sel_src, es);
        chk({t, " sel_vec"}, sel_vec, ev);
        chk("R10 need_delivery", need_delivery, (es != 0 && !blocked) ? 1 : 0);
        chk("R6 pic strobe", pic_ack_stb, (ack_req && ack_src == 4) ? 1 : 0);
        chk("R7 apic strobe", apic_ack_stb, (ack_req && ack_src == 5) ? 1 : 0);
        if (apic_ack_stb) chk("R7 apic ack vector", apic_ack_vec, ack_vec);
        rs = 0; rv = 0;
        t = "R8";
        if (ack_req) begin
            case (ack_src)
                3'd1: begin t = "R5"; if (m_nmi != 0) begin rs = 1; rv = 2; end end
                3'd2: begin t = "R5"; if (m_mce != 0) begin rs = 2; rv = 18; end end
                3'd3: begin rs = 3; rv = ack_vec; end
                3'd4: begin t = "R6"; if (pic_ack_valid) begin rs = 4; rv = pic_ack_vec; end end
                3'd5: begin t = "R7"; if (apic_ack_ok) begin rs = 5; rv = ack_vec; end end
                default: ;
            endcase
        end
        nn = (nmi_set || (m_nmi != 0 && !(ack_req && ack_src == 1))) ? 1 : 0;
        nm = (mce_set || (m_mce != 0 && !(ack_req && ack_src == 2))) ? 1 : 0;
        es = ack_req ? 1 : 0;
        @(posedge clk);
        m_nmi = nn; m_mce = nm;
        #1;
        chk("R9 ack_done", ack_done, es);
        if (es != 0) begin
            chk({t, " ack src"}, ack_res_src, rs);
            chk({t, " ack vec"}, ack_res_vec, rv);
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        quiet();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R11 reset state
        chk("R11 reset sel_src", sel_src, 0);
        chk("R11 reset ack_done", ack_done, 0);
        step();
        // R4 then R3 over APIC, R2 over PIC
        apic_valid = 1; step();
        apic_accepts_pic = 1; pic_out = 1; step();
        via_is_vector = 1; step();
        evt_pending = 1; cb_vector = 8'hF3; step();
        // R5 both flags, priority NMI over MCE
        nmi_set = 1; mce_set = 1; step();
        nmi_set = 0; mce_set = 0; blocked = 1; step();
        blocked = 0; ack_req = 1; ack_src = 1; step();
        ack_src = 1; step();                       // stale: none
        ack_src = 2; step();
        ack_src = 2; mce_set = 1; step();          // set wins
        mce_set = 0; ack_src = 3; ack_vec = 8'h77; step();
        ack_src = 4; pic_ack_valid = 1; pic_ack_vec = 8'h09; step();
        pic_ack_valid = 0; step();
        ack_src = 5; ack_vec = 8'h31; apic_ack_ok = 1; step();
        apic_ack_ok = 0; step();
        ack_src = 6; step();
        ack_src = 0; step();
        quiet(); step();
        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            nmi_set = ($urandom_range(0, 9) == 0);
            mce_set = ($urandom_range(0, 9) == 0);
            via_is_vector = $urandom_range(0, 1);
            evt_pending = $urandom_range(0, 1);
            cb_vector = 8'($urandom);
            apic_accepts_pic = $urandom_range(0, 1);
            pic_out = $urandom_range(0, 1);
            apic_valid = $urandom_range(0, 1);
            apic_vector = 8'($urandom);
            blocked = ($urandom_range(0, 3) == 0);
            ack_req = $urandom_range(0, 1);
            ack_src = 3'($urandom);
            ack_vec = 8'($urandom);
            pic_ack_valid = $urandom_range(0, 1);
            pic_ack_vec = 8'($urandom);
            apic_ack_ok = $urandom_range(0, 1);
            step();
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule